// File: doc/BRIEF.md
# Row Scan and Scroll Mapper

This block sequences the row scan of a dot-matrix display driver built for 32 graphic lines plus one icon line, each 120 pixels wide. A phase counter, advanced by the display clock enable, divides time into row periods. At the end of each period the block presents the memory row address for the next scan slot, takes that row's pixel data from display memory, and registers a 120-bit segment vector together with a one-hot 33-bit common select for the slot.

Vertical scroll, row reversal and column reversal are applied on the way out. The icon line is always the last slot and is never remapped. Configuration inputs select 1/16, 1/32 or 1/33 multiplexing, an icon-only low-power mode, display on/off and the slow or normal row period. A frame polarity output toggles at the start of every frame so the downstream level selector can drive the panel with alternating polarity.

Display memory is read combinationally: `mem_row` is stable for a whole row period and `mem_data` must return that row's bits in the same period.

Top module: `row_scan_mapper`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `com_out`, `seg_out`, `dummy_scan` and `frame_pol` to 0. After `rst` is released, it starts the scan so that the first row period displays slot 0.
- R2: A row period lasts 24 ticks when `fast_rate`=1 and 18 ticks when `fast_rate`=0. A tick is a clock edge with `tick`=1. Outputs change only at the edge of the last tick of a period, and cycles without a tick do not advance the scan.
- R3: `mux_sel` encodes the multiplex ratio: 00 is 1/16, 01 is 1/32, 10 is 1/33 and 11 behaves as 1/32. A frame has 33 slots for 1/33 or when `icon_only`=1, and 32 slots otherwise. In 1/32 a frame therefore lasts 576 ticks (slow) or 768 ticks (normal).
- R4: `frame_pol` toggles at the edge that starts slot 0 of each frame.
- R5: Slot L (0..31) of a displayed graphic line shows memory row (L + `scroll`) mod 32, read through `mem_row`.
- R6: A graphic slot L drives exactly one common: index 31−L when `row_rev`=1 and index L otherwise. `com_out` is never more than one-hot.
- R7: With `col_rev`=1, `seg_out[k]` of a graphic slot equals bit 119−k of the memory row. With `col_rev`=0 it equals bit k.
- R8: Slot 32 drives common 32 with memory row 32, unaffected by `scroll`, `row_rev` and `col_rev`.
- R9: In 1/16 mode, slots 16..31 are dummy scans: `dummy_scan`=1, `com_out`=0 and `seg_out`=0.
- R10: With `icon_only`=1, slots 0..31 drive no common and no segment data. Only slot 32 is active.
- R11: With `disp_on`=0, `com_out`, `seg_out` and `dummy_scan` are 0 in every slot, while slot timing and `frame_pol` keep running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Display clock enable |
| disp_on | input | 1 | Display enable |
| icon_only | input | 1 | Icon-only low-power mode |
| mux_sel | input | 2 | Multiplex ratio select |
| fast_rate | input | 1 | 1: 24-tick row period, 0: 18-tick |
| scroll | input | 5 | Vertical scroll amount |
| row_rev | input | 1 | Reverse common order of graphic lines |
| col_rev | input | 1 | Reverse segment order of graphic lines |
| mem_row | output | 6 | Memory row for the upcoming slot |
| mem_data | input | 120 | Pixel data of row `mem_row` |
| seg_out | output | 120 | Segment vector of the current slot |
| com_out | output | 33 | One-hot common select |
| dummy_scan | output | 1 | Current slot is a 1/16 dummy scan |
| frame_pol | output | 1 | Frame polarity |

## Verification
Every result is due at the clock edge that carries the last tick of a row period: 18 or 24 counted ticks after release from reset, and each further period after that. The registers load at that edge, so their values are visible half a clock later. The bench records at the clock edge whether a tick was accepted, counts accepted ticks itself, and at the falling edge after each period's last tick pops one predicted slot from its queue and compares commons, segments, dummy flag and polarity. One phase spaces ticks three cycles apart, so a design that counted clocks instead of ticks would land on the wrong edge.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int DEF_COLS     = 120;
    localparam int DEF_LINES    = 32;
    localparam int DEF_SLOW_LEN = 18;
    localparam int DEF_NORM_LEN = 24;

    typedef enum logic [1:0] {
        MUX_16  = 2'b00,
        MUX_32  = 2'b01,
        MUX_33  = 2'b10,
        MUX_RSV = 2'b11
    } mux_e;

    typedef enum logic [1:0] {
        SL_LINE,
        SL_ICON,
        SL_DUMMY,
        SL_BLANK
    } slot_kind_e;

    function automatic bit drives_panel(slot_kind_e k);
        return (k == SL_LINE) || (k == SL_ICON);
    endfunction

endpackage

// File: rtl/scan_timer.sv
module scan_timer #(
    parameter int SLOW_LEN = 18,
    parameter int NORM_LEN = 24,
    parameter int SLOT_W   = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              fast_rate,
    input  logic [SLOT_W-1:0] slot_count,
    output logic              boundary,
    output logic [SLOT_W-1:0] next_slot,
    output logic              polarity
);
    localparam int MAX_LEN = (NORM_LEN > SLOW_LEN) ? NORM_LEN : SLOW_LEN;
    localparam int PH_W    = $clog2(MAX_LEN);

    logic [PH_W-1:0]   phase;
    logic [PH_W-1:0]   last_phase;
    logic [SLOT_W-1:0] slot;

    assign last_phase = fast_rate ? PH_W'(NORM_LEN - 1) : PH_W'(SLOW_LEN - 1);
    assign boundary   = tick && (phase >= last_phase);
    assign next_slot  = (slot >= slot_count - SLOT_W'(1)) ? '0 : slot + SLOT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= '0;
            slot     <= '1;
            polarity <= 1'b0;
        end else if (tick) begin
            if (boundary) begin
                phase <= '0;
                slot  <= next_slot;
                if (next_slot == '0)
                    polarity <= ~polarity;
            end else begin
                phase <= phase + PH_W'(1);
            end
        end
    end

endmodule

// File: rtl/scan_row_map.sv
module scan_row_map
    import scan_pkg::*;
#(
    parameter int LINES  = 32,
    parameter int SLOT_W = 6
) (
    input  logic                     disp_on,
    input  logic                     icon_only,
    input  mux_e                     mux,
    input  logic                     row_rev,
    input  logic [$clog2(LINES)-1:0] scroll,
    input  logic [SLOT_W-1:0]        slot,
    output slot_kind_e               kind,
    output logic [SLOT_W-1:0]        mem_row,
    output logic [SLOT_W-1:0]        com_idx
);
    localparam int LW = $clog2(LINES);

    logic [LW-1:0] line;
    logic [LW-1:0] shifted;
    logic [LW-1:0] placed;
    logic          is_icon;

    assign line    = slot[LW-1:0];
    assign is_icon = (slot == SLOT_W'(LINES));
    assign shifted = line + scroll;
    assign placed  = row_rev ? (LW'(LINES - 1) - line) : line;
    assign mem_row = is_icon ? SLOT_W'(LINES) : SLOT_W'(shifted);
    assign com_idx = is_icon ? SLOT_W'(LINES) : SLOT_W'(placed);

    always_comb begin
        if (!disp_on)
            kind = SL_BLANK;
        else if (is_icon)
            kind = SL_ICON;
        else if (icon_only)
            kind = SL_BLANK;
        else if (mux == MUX_16 && line >= LW'(LINES / 2))
            kind = SL_DUMMY;
        else
            kind = SL_LINE;
    end

endmodule

// File: rtl/scan_col_map.sv
module scan_col_map #(
    parameter int COLS = 120
) (
    input  logic            col_rev,
    input  logic            keep_order,
    input  logic [COLS-1:0] row_bits,
    output logic [COLS-1:0] seg_bits
);
    logic flip;
    assign flip = col_rev && !keep_order;

    for (genvar k = 0; k < COLS; k++) begin : g_col
        assign seg_bits[k] = flip ? row_bits[COLS-1-k] : row_bits[k];
    end

endmodule

// File: rtl/row_scan_mapper.sv
module row_scan_mapper
    import scan_pkg::*;
#(
    parameter int COLS     = DEF_COLS,
    parameter int LINES    = DEF_LINES,
    parameter int SLOW_LEN = DEF_SLOW_LEN,
    parameter int NORM_LEN = DEF_NORM_LEN
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     tick,
    input  logic                     disp_on,
    input  logic                     icon_only,
    input  logic [1:0]               mux_sel,
    input  logic                     fast_rate,
    input  logic [$clog2(LINES)-1:0] scroll,
    input  logic                     row_rev,
    input  logic                     col_rev,
    output logic [$clog2(LINES+1)-1:0] mem_row,
    input  logic [COLS-1:0]          mem_data,
    output logic [COLS-1:0]          seg_out,
    output logic [LINES:0]           com_out,
    output logic                     dummy_scan,
    output logic                     frame_pol
);
    localparam int SLOT_W = $clog2(LINES + 1);
    localparam int NCOM   = LINES + 1;

    mux_e              mux;
    logic [SLOT_W-1:0] slot_count;
    logic              boundary;
    logic [SLOT_W-1:0] next_slot;
    slot_kind_e        kind;
    logic [SLOT_W-1:0] com_idx;
    logic [COLS-1:0]   mapped;
    logic [COLS-1:0]   seg_d;
    logic [NCOM-1:0]   com_d;
    logic              drive;

    assign mux        = mux_e'(mux_sel);
    assign slot_count = (icon_only || mux == MUX_33) ? SLOT_W'(NCOM) : SLOT_W'(LINES);

    scan_timer #(
        .SLOW_LEN (SLOW_LEN),
        .NORM_LEN (NORM_LEN),
        .SLOT_W   (SLOT_W)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .fast_rate  (fast_rate),
        .slot_count (slot_count),
        .boundary   (boundary),
        .next_slot  (next_slot),
        .polarity   (frame_pol)
    );

    scan_row_map #(
        .LINES  (LINES),
        .SLOT_W (SLOT_W)
    ) u_rows (
        .disp_on   (disp_on),
        .icon_only (icon_only),
        .mux       (mux),
        .row_rev   (row_rev),
        .scroll    (scroll),
        .slot      (next_slot),
        .kind      (kind),
        .mem_row   (mem_row),
        .com_idx   (com_idx)
    );

    scan_col_map #(
        .COLS (COLS)
    ) u_cols (
        .col_rev    (col_rev),
        .keep_order (kind == SL_ICON),
        .row_bits   (mem_data),
        .seg_bits   (mapped)
    );

    assign drive = drives_panel(kind);
    assign seg_d = drive ? mapped : '0;

    for (genvar i = 0; i < NCOM; i++) begin : g_com
        assign com_d[i] = drive && (com_idx == SLOT_W'(i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_out    <= '0;
            com_out    <= '0;
            dummy_scan <= 1'b0;
        end else if (boundary) begin
            seg_out    <= seg_d;
            com_out    <= com_d;
            dummy_scan <= (kind == SL_DUMMY);
        end
    end

endmodule

// File: rtl/row_scan_mapper_chk.sv
module row_scan_mapper_chk #(
    parameter int COLS  = 120,
    parameter int LINES = 32
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       tick,
    input logic                       disp_on,
    input logic                       icon_only,
    input logic [$clog2(LINES+1)-1:0] mem_row,
    input logic [COLS-1:0]            seg_out,
    input logic [LINES:0]             com_out,
    input logic                       dummy_scan,
    input logic                       frame_pol
);
    AST_COM_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(com_out)); // R6

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(tick)) |->
            ($stable(com_out) && $stable(seg_out) && $stable(frame_pol))); // R2

    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(disp_on) && !$past(rst)) |->
            (com_out == '0 && seg_out == '0 && !dummy_scan)); // R11

    AST_ICON_ONLY_QUIET: assert property (@(posedge clk) disable iff (rst)
        ($past(icon_only) && !$past(rst)) |-> (com_out[LINES-1:0] == '0)); // R10

    AST_DUMMY_BLANK: assert property (@(posedge clk) disable iff (rst)
        dummy_scan |-> (com_out == '0 && seg_out == '0)); // R9

    AST_ROW_RANGE: assert property (@(posedge clk) disable iff (rst)
        mem_row <= ($clog2(LINES+1))'(LINES)); // R5

endmodule

bind row_scan_mapper row_scan_mapper_chk #(
    .COLS  (COLS),
    .LINES (LINES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .disp_on    (disp_on),
    .icon_only  (icon_only),
    .mem_row    (mem_row),
    .seg_out    (seg_out),
    .com_out    (com_out),
    .dummy_scan (dummy_scan),
    .frame_pol  (frame_pol)
);

// File: tb/row_scan_mapper_tb.sv
`timescale 1ns/1ps
module row_scan_mapper_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick = 1'b0;
    logic         disp_on = 1'b0;
    logic         icon_only = 1'b0;
    logic [1:0]   mux_sel = 2'b01;
    logic         fast_rate = 1'b0;
    logic [4:0]   scroll = '0;
    logic         row_rev = 1'b0;
    logic         col_rev = 1'b0;
    logic [5:0]   mem_row;
    logic [119:0] mem_data;
    logic [119:0] seg_out;
    logic [32:0]  com_out;
    logic         dummy_scan;
    logic         frame_pol;

    always #10 clk = ~clk;

    row_scan_mapper u_dut (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .disp_on    (disp_on),
        .icon_only  (icon_only),
        .mux_sel    (mux_sel),
        .fast_rate  (fast_rate),
        .scroll     (scroll),
        .row_rev    (row_rev),
        .col_rev    (col_rev),
        .mem_row    (mem_row),
        .mem_data   (mem_data),
        .seg_out    (seg_out),
        .com_out    (com_out),
        .dummy_scan (dummy_scan),
        .frame_pol  (frame_pol)
    );

    logic [119:0] mem [33];
    assign mem_data = (mem_row <= 6'd32) ? mem[mem_row] : '0;

    typedef struct {
        logic [32:0]  com;
        logic [119:0] seg;
        logic         dummy;
        logic         pol;
        string        tag;
        int           slot;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    int   gap_n = 1;
    int   gcnt  = 0;
    int   tcnt  = 0;
    bit   tick_seen = 1'b0;
    bit   pol_exp = 1'b0;
    bit   done = 1'b0;

    function automatic logic [119:0] flip120(logic [119:0] v);
        logic [119:0] r;
        for (int k = 0; k < 120; k++) r[k] = v[119-k];
        return r;
    endfunction

    task automatic check(bit ok, string tag, string what, logic [127:0] act, logic [127:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // tick driver
    always @(negedge clk) begin
        gcnt = (gcnt + 1) % gap_n;
        tick <= (gcnt == 0);
    end

    always @(posedge clk) tick_seen <= tick && !rst;

    // monitor
    always @(negedge clk) begin
        if (rst) begin
            tcnt = 0;
        end else if (tick_seen) begin
            tcnt++;
            if (tcnt == (fast_rate ? 24 : 18)) begin
                tcnt = 0;
                if (q.size() != 0) begin
                    exp_t e;
                    e = q.pop_front();
                    check(com_out === e.com, e.tag, $sformatf("com slot %0d", e.slot), 128'(com_out), 128'(e.com));
                    check(seg_out === e.seg, e.tag, $sformatf("seg slot %0d", e.slot), 128'(seg_out), 128'(e.seg));
                    check(dummy_scan === e.dummy, e.tag, $sformatf("dummy slot %0d", e.slot), 128'(dummy_scan), 128'(e.dummy));
                    check(frame_pol === e.pol, "R4", $sformatf("pol slot %0d", e.slot), 128'(frame_pol), 128'(e.pol));
                end
            end
        end
    end

    task automatic push_slots(string tag, int n);
        int nsl;
        int L;
        nsl = (icon_only || mux_sel == 2'b10) ? 33 : 32;
        L = 0;
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.com = '0; e.seg = '0; e.dummy = 1'b0;
            if (disp_on) begin
                if (L == 32) begin
                    e.com[32] = 1'b1;                  // R8
                    e.seg = mem[32];
                end else if (!icon_only) begin
                    if (mux_sel == 2'b00 && L >= 16) begin
                        e.dummy = 1'b1;                // R9
                    end else begin
                        int r;
                        int pc;
                        r  = (L + int'(scroll)) % 32;  // R5
                        pc = row_rev ? 31 - L : L;     // R6
                        e.com[pc] = 1'b1;
                        e.seg = col_rev ? flip120(mem[r]) : mem[r]; // R7
                    end
                end
            end
            if (L == 0) pol_exp = !pol_exp;
            e.pol  = pol_exp;
            e.tag  = tag;
            e.slot = L;
            q.push_back(e);
            L = (L + 1) % nsl;
        end
    endtask

    task automatic run_phase(string tag, int n, logic on, logic ico, logic [1:0] mx,
                             logic fst, logic [4:0] sc, logic rr, logic cr, int gap);
        int guard;
        @(negedge clk);
        rst = 1'b1;
        disp_on = on; icon_only = ico; mux_sel = mx; fast_rate = fst;
        scroll = sc; row_rev = rr; col_rev = cr; gap_n = gap; gcnt = 0;
        repeat (3) @(negedge clk);
        check(com_out === '0, "R1", "reset com", 128'(com_out), 128'(0));
        check(seg_out === '0, "R1", "reset seg", 128'(seg_out), 128'(0));
        check(frame_pol === 1'b0 && dummy_scan === 1'b0, "R1", "reset pol/dummy",
              128'({frame_pol, dummy_scan}), 128'(0));
        pol_exp = 1'b0;
        push_slots(tag, n);
        rst = 1'b0;
        guard = 0;
        while (q.size() != 0 && guard < 40000) begin
            @(negedge clk);
            guard++;
        end
        if (q.size() != 0) begin
            check(1'b0, tag, "queue not drained", 128'(q.size()), 128'(0));
            q.delete();
        end
    endtask

    initial begin
        for (int r = 0; r < 33; r++)
            for (int k = 0; k < 120; k++)
                mem[r][k] = (((k * 7 + r * 13) % 5) == 0) ^ (k == r) ^ (k < r / 3);
        //        tag    n   on ico mux  fst sc  rr cr gap
        run_phase("R5",  33, 1, 0, 2'b01, 1, 0,  0, 0, 1);
        run_phase("R6",  32, 1, 0, 2'b01, 0, 0,  1, 0, 1);
        run_phase("R7",  20, 1, 0, 2'b01, 1, 3,  0, 1, 1);
        run_phase("R8",  34, 1, 0, 2'b10, 0, 9,  1, 1, 1);
        run_phase("R9",  33, 1, 0, 2'b00, 1, 31, 0, 0, 1);
        run_phase("R10", 34, 1, 1, 2'b01, 0, 4,  1, 1, 1);
        run_phase("R11", 35, 0, 0, 2'b10, 1, 2,  0, 0, 1);
        run_phase("R2",  10, 1, 0, 2'b01, 0, 17, 0, 1, 3);
        run_phase("R3",  33, 1, 0, 2'b11, 1, 6,  1, 0, 1);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #4000000;
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL R2 watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule